// File: doc/BRIEF.md
# Binary64 Round-to-Integer Unit

This unit takes one IEEE-754 binary64 operand and a two-bit rounding selector. It returns the operand rounded to an integral value, still encoded as binary64. The result is registered, so an accepted operand produces its result on the next clock. The unit never traps and holds no status. It only drives per-result flag strobes, which a surrounding status register can accumulate.

Each operand is first sorted into one of seven classes: zero, below-one (nonzero magnitude under 1.0, denormals included), fractional (unbiased exponent 0 to 51), integral (unbiased exponent 52 or more), infinity, quiet NaN and signalling NaN. The class selects the result path. Signalling NaNs are quieted. Every other non-finite or already-integral value passes through untouched. Finite values with a fractional part are rounded by masking the mantissa and, when needed, adding one unit in the last integral place.

Rounding never raises the inexact strobe, and the integer-conversion invalid strobe is never raised either. The only flag that can fire is the signalling-NaN invalid strobe.

Top module: `fri_unit`

## Requirements
- R1: After reset `out_valid` is 0. `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high, and the result and flags for that operand appear together with it.
- R2: Selector 2'b00 rounds to the nearest integer, and exact halfway cases go away from zero (2.5 gives 3.0, -2.5 gives -3.0, 0.5 gives 1.0).
- R3: Selector 2'b01 rounds toward zero: the fractional part is dropped.
- R4: Selector 2'b10 rounds toward +infinity and selector 2'b11 rounds toward -infinity.
- R5: A signalling NaN (exponent all ones, nonzero fraction, fraction bit 51 clear) returns the operand with bit 51 set, keeping its sign and payload. It raises `out_snan_invalid` and leaves `out_cvt_invalid` low.
- R6: A quiet NaN (fraction bit 51 set) or an infinity of either sign returns unchanged, with every flag low.
- R7: `out_inexact` is never raised, even when nonzero fraction bits are discarded.
- R8: A finite operand whose unbiased exponent is 52 or more returns bit-identical.
- R9: A nonzero operand below 1.0 in magnitude, denormals included, returns ±0.0 or ±1.0 as the mode dictates. The result keeps the operand's sign, so results of -0.0 occur.
- R10: +0.0 and -0.0 return unchanged with no flag.
- R11: When rounding up carries out of the mantissa (for example 1.5 toward +infinity, or 2^52-0.5 to nearest), the exponent rises by one and the fraction becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand is presented this cycle |
| in_operand | input | 64 | Binary64 operand |
| in_mode | input | 2 | 00 nearest-away, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result is valid this cycle |
| out_result | output | 64 | Rounded binary64 result |
| out_snan_invalid | output | 1 | Strobe: operand was a signalling NaN |
| out_cvt_invalid | output | 1 | Strobe: invalid integer conversion (never raised) |
| out_inexact | output | 1 | Strobe: inexact (never raised) |

## Verification
Every result and every flag is due exactly one clock after the operand is presented, on the same edge that raises `out_valid`. Each expected value is queued when the operand is driven on a falling edge. One nanosecond after every rising edge the monitor pops the queue only if `out_valid` is high, and a valid pulse with nothing queued, or a queued entry with no pulse, counts as a failure. Expected results come from real-valued floor arithmetic on the magnitude with the sign reattached, which is independent of the mantissa-masking datapath.

// File: rtl/fri_pkg.sv
package fri_pkg;

    localparam int unsigned DP_EXP_W  = 11;
    localparam int unsigned DP_FRAC_W = 52;

    // Rounding selector encoding (fixed by the port contract)
    typedef enum logic [1:0] {
        RM_NEAR_AWAY = 2'b00,
        RM_TRUNC     = 2'b01,
        RM_CEIL      = 2'b10,
        RM_FLOOR     = 2'b11
    } rmode_e;

    // Operand classes; each selects one result path
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB_ONE,
        CLS_FRACTIONAL,
        CLS_INTEGRAL,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } opcls_e;

    // Shared increment decision for every finite path that drops bits
    function automatic logic round_up(input rmode_e mode, input logic sgn,
                                      input logic has_frac, input logic at_half);
        logic up;
        unique case (mode)
            RM_NEAR_AWAY: up = at_half;
            RM_TRUNC:     up = 1'b0;
            RM_CEIL:      up = has_frac & ~sgn;
            RM_FLOOR:     up = has_frac & sgn;
            default:      up = 1'b0;
        endcase
        return up;
    endfunction

endpackage

// File: rtl/fri_classify.sv
module fri_classify
    import fri_pkg::*;
#(
    parameter int unsigned EXP_W  = DP_EXP_W,
    parameter int unsigned FRAC_W = DP_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] op,
    output opcls_e            cls
);

    localparam logic [EXP_W-1:0] BIAS    = EXP_W'((1 << (EXP_W - 1)) - 1);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam logic [EXP_W-1:0] INT_EXP = BIAS + EXP_W'(FRAC_W);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = op[WORD_W-2 -: EXP_W];
    assign frac_f = op[FRAC_W-1:0];

    always_comb begin
        if (exp_f == EXP_MAX) begin
            if (frac_f == '0)          cls = CLS_INF;
            else if (frac_f[FRAC_W-1]) cls = CLS_QNAN;
            else                       cls = CLS_SNAN;
        end else if (exp_f == '0 && frac_f == '0) begin
            cls = CLS_ZERO;
        end else if (exp_f < BIAS) begin
            cls = CLS_SUB_ONE;
        end else if (exp_f >= INT_EXP) begin
            cls = CLS_INTEGRAL;
        end else begin
            cls = CLS_FRACTIONAL;
        end
    end

endmodule

// File: rtl/fri_round_core.sv
module fri_round_core
    import fri_pkg::*;
#(
    parameter int unsigned EXP_W  = DP_EXP_W,
    parameter int unsigned FRAC_W = DP_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] op,
    input  rmode_e            mode,
    input  opcls_e            cls,
    output logic [WORD_W-1:0] res,
    output logic              snan
);

    localparam int unsigned MANT_W = FRAC_W + 1;
    localparam int unsigned SH_W   = $clog2(FRAC_W + 1);
    localparam logic [EXP_W-1:0] BIAS = EXP_W'((1 << (EXP_W - 1)) - 1);
    localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);

    logic              sgn;
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign sgn    = op[WORD_W-1];
    assign exp_f  = op[WORD_W-2 -: EXP_W];
    assign frac_f = op[FRAC_W-1:0];

    // Below-one path: result magnitude is 0 or 1
    logic sub_up;
    assign sub_up = round_up(mode, sgn, 1'b1, exp_f == (BIAS - EXP_W'(1)));

    // Fractional path: mask off the fraction bits, add one integral unit if needed
    logic [EXP_W-1:0]  ue;
    logic [SH_W-1:0]   fbits;
    logic [MANT_W-1:0] mant;
    logic [MANT_W:0]   one_unit;
    logic [MANT_W:0]   mask_w;
    logic [MANT_W-1:0] frac_part;
    logic [MANT_W-1:0] int_part;
    logic [MANT_W-1:0] half;
    logic              frac_up;
    logic [MANT_W:0]   sum;
    logic              carry;

    always_comb begin
        ue        = exp_f - BIAS;
        fbits     = SH_W'(FRAC_W) - ue[SH_W-1:0];
        mant      = {1'b1, frac_f};
        one_unit  = (MANT_W + 1)'(1) << fbits;
        mask_w    = one_unit - (MANT_W + 1)'(1);
        frac_part = mant & mask_w[MANT_W-1:0];
        int_part  = mant & ~mask_w[MANT_W-1:0];
        half      = one_unit[MANT_W:1];
        frac_up   = round_up(mode, sgn, |frac_part, |(frac_part & half));
        sum       = {1'b0, int_part} + (frac_up ? one_unit : '0);
        carry     = sum[MANT_W];
    end

    always_comb begin
        res  = op;
        snan = 1'b0;
        unique case (cls)
            CLS_SNAN: begin
                res  = op | QUIET_BIT;
                snan = 1'b1;
            end
            CLS_SUB_ONE: begin
                res = {sgn, (sub_up ? BIAS : {EXP_W{1'b0}}), {FRAC_W{1'b0}}};
            end
            CLS_FRACTIONAL: begin
                if (carry) res = {sgn, exp_f + EXP_W'(1), {FRAC_W{1'b0}}};
                else       res = {sgn, exp_f, sum[FRAC_W-1:0]};
            end
            CLS_ZERO, CLS_INTEGRAL, CLS_INF, CLS_QNAN: begin
                res = op;
            end
            default: res = op;
        endcase
    end

endmodule

// File: rtl/fri_unit.sv
module fri_unit
    import fri_pkg::*;
#(
    parameter int unsigned EXP_W  = DP_EXP_W,
    parameter int unsigned FRAC_W = DP_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_operand,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_snan_invalid,
    output logic              out_cvt_invalid,
    output logic              out_inexact
);

    opcls_e            cls;
    logic [WORD_W-1:0] res_c;
    logic              snan_c;

    fri_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .op  (in_operand),
        .cls (cls)
    );

    fri_round_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
        .op   (in_operand),
        .mode (rmode_e'(in_mode)),
        .cls  (cls),
        .res  (res_c),
        .snan (snan_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid        <= 1'b0;
            out_result       <= '0;
            out_snan_invalid <= 1'b0;
        end else begin
            out_valid        <= in_valid;
            out_snan_invalid <= in_valid & snan_c;
            if (in_valid) out_result <= res_c;
        end
    end

    // Rounding to an integral value reports neither of these conditions
    assign out_cvt_invalid = 1'b0;
    assign out_inexact     = 1'b0;

endmodule

// File: rtl/fri_unit_chk.sv
module fri_unit_chk #(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_operand,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_result,
    input logic              out_snan_invalid
);

    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam logic [EXP_W-1:0] INT_EXP = EXP_W'((1 << (EXP_W - 1)) - 1 + FRAC_W);

    logic [EXP_W-1:0] in_exp;
    logic             in_is_nan;
    logic             in_is_snan;

    assign in_exp     = in_operand[WORD_W-2 -: EXP_W];
    assign in_is_nan  = (in_exp == EXP_MAX) && (in_operand[FRAC_W-1:0] != '0);
    assign in_is_snan = in_is_nan && !in_operand[FRAC_W-1];

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_snan_invalid);

    a_r9_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_result[WORD_W-1] == $past(in_operand[WORD_W-1]));

    a_r5_snan_quieted: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_is_snan |=> out_snan_invalid &&
            out_result == ($past(in_operand) | (WORD_W'(1) << (FRAC_W - 1))));

    a_r6_special_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_exp == EXP_MAX) && !in_is_snan |=>
            !out_snan_invalid && out_result == $past(in_operand));

    a_r8_integral_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_exp >= INT_EXP) && (in_exp != EXP_MAX) |=>
            out_result == $past(in_operand));

endmodule

bind fri_unit fri_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid         (in_valid),
    .in_operand       (in_operand),
    .out_valid        (out_valid),
    .out_result       (out_result),
    .out_snan_invalid (out_snan_invalid)
);

// File: tb/fri_unit_tb_top.sv
`timescale 1ns/1ps
module fri_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_mode = 2'b00;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_snan_invalid;
    logic        out_cvt_invalid;
    logic        out_inexact;

    int errs = 0;
    int checks = 0;

    logic [63:0] exp_q [$];
    logic        snan_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    fri_unit dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .in_valid         (in_valid),
        .in_operand       (in_operand),
        .in_mode          (in_mode),
        .out_valid        (out_valid),
        .out_result       (out_result),
        .out_snan_invalid (out_snan_invalid),
        .out_cvt_invalid  (out_cvt_invalid),
        .out_inexact      (out_inexact)
    );

    // Reference: real-valued floor on the magnitude, sign reattached
    function automatic logic [64:0] ref_round(input logic [63:0] op, input logic [1:0] md);
        logic sg;
        logic [10:0] ex;
        logic [51:0] fr;
        real a, t, r;
        logic [63:0] b;
        sg = op[63];
        ex = op[62:52];
        fr = op[51:0];
        if (ex == 11'h7FF) begin
            if (fr != 0 && !fr[51]) return {1'b1, op | 64'h0008_0000_0000_0000};
            return {1'b0, op};
        end
        if (ex == 0 && fr == 0) return {1'b0, op};
        a = $bitstoreal({1'b0, op[62:0]});
        t = $floor(a);
        case (md)
            2'b00:   r = (a - t >= 0.5) ? t + 1.0 : t;
            2'b01:   r = t;
            2'b10:   r = (!sg && a > t) ? t + 1.0 : t;
            default: r = (sg && a > t) ? t + 1.0 : t;
        endcase
        b = $realtobits(r);
        b[63] = sg;
        return {1'b0, b};
    endfunction

    task automatic drive(input logic [63:0] op, input logic [1:0] md, input string tag);
        logic [64:0] e;
        @(negedge clk);
        in_valid   = 1'b1;
        in_operand = op;
        in_mode    = md;
        e = ref_round(op, md);
        exp_q.push_back(e[63:0]);
        snan_q.push_back(e[64]);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare on every clock, 1 ns after the rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errs++;
                    $display("FAIL R1: out_valid=1 expected 0 (nothing pending)");
                end else begin
                    logic [63:0] ev;
                    logic es;
                    string tg;
                    ev = exp_q.pop_front();
                    es = snan_q.pop_front();
                    tg = tag_q.pop_front();
                    checks++;
                    if (out_result !== ev) begin
                        errs++;
                        $display("FAIL %s: result=%h expected %h", tg, out_result, ev);
                    end
                    checks++;
                    if (out_snan_invalid !== es || out_cvt_invalid !== 1'b0) begin
                        errs++;
                        $display("FAIL R5 (%s): snan=%b cvt=%b expected snan=%b cvt=0",
                                 tg, out_snan_invalid, out_cvt_invalid, es);
                    end
                    checks++;
                    if (out_inexact !== 1'b0) begin
                        errs++;
                        $display("FAIL R7: inexact=%b expected 0", out_inexact);
                    end
                end
            end else if (exp_q.size() != 0) begin
                checks++; errs++;
                $display("FAIL R1: out_valid=0 expected 1");
                exp_q.pop_front(); snan_q.pop_front(); tag_q.pop_front();
            end
        end
    end

    initial begin
        #400000;
        errs++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_snan_invalid !== 1'b0) begin
            errs++;
            $display("FAIL R1: reset out_valid=%b snan=%b expected 0 0", out_valid, out_snan_invalid);
        end
        rst_n = 1'b1;
        idle(2);

        // R2 nearest ties away
        drive(64'h4004_0000_0000_0000, 2'b00, "R2 2.5");
        drive(64'hC004_0000_0000_0000, 2'b00, "R2 -2.5");
        drive(64'h3FE0_0000_0000_0000, 2'b00, "R2 0.5");
        drive(64'h4002_0000_0000_0000, 2'b00, "R2 2.25");
        // R3 toward zero
        drive(64'hC00C_0000_0000_0000, 2'b01, "R3 -3.5");
        drive(64'h4005_9999_9999_999A, 2'b01, "R3 2.7");
        // R4 directed
        drive(64'h4002_0000_0000_0000, 2'b10, "R4 ceil 2.25");
        drive(64'hC002_0000_0000_0000, 2'b10, "R4 ceil -2.25");
        drive(64'h4002_0000_0000_0000, 2'b11, "R4 floor 2.25");
        drive(64'hC002_0000_0000_0000, 2'b11, "R4 floor -2.25");
        // R5 signalling NaN, both signs
        drive(64'h7FF0_0000_0000_0001, 2'b00, "R5 snan");
        drive(64'hFFF4_5678_9ABC_DEF0, 2'b10, "R5 -snan");
        // R6 quiet NaN and infinities
        drive(64'h7FF8_0000_0000_1234, 2'b01, "R6 qnan");
        drive(64'h7FF0_0000_0000_0000, 2'b00, "R6 +inf");
        drive(64'hFFF0_0000_0000_0000, 2'b11, "R6 -inf");
        // R8 already integral
        drive(64'h4340_0000_0000_0001, 2'b10, "R8 2^53+2");
        drive(64'hC330_0000_0000_0001, 2'b11, "R8 -(2^52+1)");
        // R9 below one, denormals, -0.0 results
        drive(64'hBFD3_3333_3333_3333, 2'b01, "R9 -0.3 trunc");
        drive(64'hBFD3_3333_3333_3333, 2'b10, "R9 -0.3 ceil");
        drive(64'hBFD3_3333_3333_3333, 2'b11, "R9 -0.3 floor");
        drive(64'h3FDF_FFFF_FFFF_FFFF, 2'b00, "R9 just below half");
        drive(64'h0000_0000_0000_0001, 2'b10, "R9 denorm ceil");
        drive(64'h8000_0000_0000_0001, 2'b11, "R9 -denorm floor");
        drive(64'h8000_0000_0000_0001, 2'b10, "R9 -denorm ceil");
        // R10 zeros
        drive(64'h0000_0000_0000_0000, 2'b10, "R10 +0");
        drive(64'h8000_0000_0000_0000, 2'b00, "R10 -0");
        // R11 carry out
        drive(64'h3FF8_0000_0000_0000, 2'b10, "R11 1.5 ceil");
        drive(64'h432F_FFFF_FFFF_FFFF, 2'b00, "R11 2^52-0.5");
        drive(64'hBFEF_FFFF_FFFF_FFFF, 2'b11, "R11 -0.99 floor");
        drive(64'h400F_FFFF_FFFF_FFFF, 2'b10, "R11 3.99 ceil");
        // R1 gaps between operands
        idle(3);
        drive(64'h4004_0000_0000_0000, 2'b01, "R1 after gap");
        idle(2);

        // Mixed sweep across exponents near the integral boundary
        for (int i = 0; i < 600; i++) begin
            logic [63:0] op;
            logic [1:0] md;
            op = {$urandom, $urandom};
            op[62:52] = 11'(1000 + $urandom_range(0, 80));
            md = 2'($urandom_range(0, 3));
            if (i % 7 == 3) op[51:0] = '0;
            if (i % 5 == 1) op[51:0] = {1'b1, 51'd0} >> $urandom_range(0, 51);
            drive(op, md, md == 2'b00 ? "R2 sweep" : (md == 2'b01 ? "R3 sweep" : "R4 sweep"));
            if (i % 11 == 0) idle(1);
        end
        idle(4);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule